// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit carries out the two configuration instructions of a vector extension. One takes the new vector type from an immediate field of the instruction word. The other takes it from an integer register. In both forms the unit reads the application vector length (AVL) from integer register rs1. It works out the largest vector length the requested type allows, which is VLMAX = LMUL × VLEN / SEW. It then picks the granted length, writes that length to its vector-length register and to destination register rd, stores the new type and clears the start index.

The host pipeline presents one instruction word together with a valid strobe. The unit drives the two register-file read addresses straight from the word, and the register file returns the two values in the same cycle. Results appear one clock later:

- a completion pulse;
- an exception pulse, only for the faulting register form;
- a register-file write request.

An element width wider than the platform allows puts the type register into its invalid state and changes nothing else.

Top module: `vcfg_unit`

## Requirements
- R1: A word with bits [6:0] = 1010111, bits [14:12] = 111 and bit 31 = 0 is the immediate form. Its new vector type is bits [30:20], zero-extended to XLEN.
- R2: A word with bits [6:0] = 1010111, bits [14:12] = 111 and bits [31:25] = 1000000 is the register form. Its new vector type is the value read from register rs2 (bits [24:20]). AVL is always read from register rs1 (bits [19:15]), and rd is bits [11:7].
- R3: Any other word, or any cycle without in_valid, gives no done pulse, no write and no change to vl, vtype or vstart.
- R4: Type bits [1:0] give LMUL = 2^field, and type bits [4:2] give SEW = 8·2^field bits. VLMAX = LMUL·VLEN/SEW.
- R5: The granted length depends on rs1 and AVL:
  - rs1 = x0: VLMAX.
  - Otherwise, AVL ≤ VLMAX: AVL.
  - Otherwise, AVL < 2·VLMAX: (AVL+1)>>1.
  - Otherwise: VLMAX.
- R6: The widest allowed element is XLEN/8 bytes. It is raised to at least 8 bytes when ext_d is set, or else to at least 4 bytes when ext_f is set.
- R7: A wider SEW writes vtype = only bit XLEN-1 set. vl, vstart and the register file are unchanged, and no exception is raised.
- R8: On success, vtype takes the new type, vl and rd both receive the granted length, and vstart becomes 0.
- R9: The register form with rs2 = x0 sets vtype to only bit XLEN-1. It pulses illegal and writes nothing else.
- R10: No register-file write is requested when rd = x0.
- R11: done (and illegal, when it applies) rise one clock after the accepted cycle and last one cycle. rd_we, rd_idx and rd_data are valid in that same cycle.
- R12: After reset, vtype has only bit XLEN-1 set, vl = 0, vstart = 0, and done, illegal and rd_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present |
| instr | input | 32 | Instruction word |
| ext_f | input | 1 | Single-precision float extension enabled |
| ext_d | input | 1 | Double-precision float extension enabled |
| rs1_idx | output | 5 | Register-file read address for AVL |
| rs1_val | input | XLEN | Value of register rs1 |
| rs2_idx | output | 5 | Register-file read address for the register-form type |
| rs2_val | input | XLEN | Value of register rs2 |
| rd_we | output | 1 | Register-file write enable |
| rd_idx | output | 5 | Register-file write address |
| rd_data | output | XLEN | Register-file write data |
| done | output | 1 | Instruction completed |
| illegal | output | 1 | Illegal-instruction exception pulse |
| vl | output | XLEN | Granted vector length |
| vtype | output | XLEN | Current vector type |
| vstart | output | XLEN | Vector start index |

## Verification
The hardest outcome to reach is an AVL that falls strictly between VLMAX and 2·VLMAX, where the halved grant applies. Uniform random XLEN-wide AVL values would almost never land in that band. The stimulus therefore draws AVL relative to the VLMAX of the chosen type, at offsets below, at, just above, just under twice and beyond it. Directed cases pin both edges of the band for several LMUL/SEW pairs, and they sweep the float-extension flags against each element width.

// File: rtl/vcfg_unit.sv
module vcfg_unit #(
  parameter int XLEN = 32,
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic            ext_f,
  input  logic            ext_d,
  output logic [4:0]      rs1_idx,
  input  logic [XLEN-1:0] rs1_val,
  output logic [4:0]      rs2_idx,
  input  logic [XLEN-1:0] rs2_val,
  output logic            rd_we,
  output logic [4:0]      rd_idx,
  output logic [XLEN-1:0] rd_data,
  output logic            done,
  illegal,
  output logic [XLEN-1:0] vl,
  output logic [XLEN-1:0] vtype,
  output logic [XLEN-1:0] vstart
);
  localparam logic [XLEN-1:0] VT_BAD = {1'b1, {(XLEN-1){1'b0}}};
  localparam int XB   = XLEN / 8;
  localparam int MAXD = (XB > 8) ? XB : 8;
  localparam int MAXF = (XB > 4) ? XB : 4;
  localparam int W    = XLEN + 2;

  wire is_cfg   = instr[6:0] == 7'b1010111 && instr[14:12] == 3'b111;
  wire imm_form = is_cfg && !instr[31];
  wire reg_form = is_cfg && instr[31:25] == 7'b1000000;
  wire fire     = in_valid && (imm_form || reg_form);
  wire rs2_zero = reg_form && instr[24:20] == 5'd0;
  wire [4:0] rd_sel = instr[11:7];

  assign rs1_idx = instr[19:15];
  assign rs2_idx = instr[24:20];

  logic [XLEN-1:0] new_vt;
  logic [7:0]      sew_bytes;
  int unsigned     max_bytes;
  logic            sew_ok;
  logic [W-1:0]    vlmax, avl, grant;

  always_comb begin
    new_vt    = imm_form ? XLEN'(instr[30:20]) : rs2_val;
    sew_bytes = 8'd1 << new_vt[4:2];
    max_bytes = ext_d ? MAXD : (ext_f ? MAXF : XB);
    sew_ok    = 32'(sew_bytes) <= max_bytes;
    vlmax     = (W'(VLEN) << new_vt[1:0]) >> (32'(new_vt[4:2]) + 32'd3);
    avl       = W'(rs1_val);
    if (rs1_idx == 5'd0)         grant = vlmax;
    else if (avl <= vlmax)       grant = avl;
    else if (avl < (vlmax << 1)) grant = (avl + W'(1)) >> 1;
    else                         grant = vlmax;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vtype   <= VT_BAD;
      vl      <= '0;
      vstart  <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
      rd_we   <= 1'b0;
      rd_idx  <= '0;
      rd_data <= '0;
    end else begin
      done    <= fire;
      illegal <= fire && rs2_zero;
      rd_we   <= fire && !rs2_zero && sew_ok && rd_sel != 5'd0;
      rd_idx  <= rd_sel;
      rd_data <= grant[XLEN-1:0];
      if (fire) begin
        if (rs2_zero || !sew_ok) begin
          vtype <= VT_BAD;
        end else begin
          vtype  <= new_vt;
          vl     <= grant[XLEN-1:0];
          vstart <= '0;
        end
      end
    end
  end

  function automatic logic [W-1:0] vlmax_of(input logic [XLEN-1:0] t);
    return (W'(VLEN) << t[1:0]) >> (32'(t[4:2]) + 32'd3);
  endfunction

  // R9
  illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!rd_we && vtype == VT_BAD && done));
  // R8
  write_matches_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (rd_data == vl && vstart == '0 && done));
  // R10
  no_x0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> rd_idx != 5'd0);
  // R5
  vl_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> W'(rd_data) <= vlmax_of(vtype));
  // R3
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!done && $stable(vl) && $stable(vtype) && $stable(vstart)));
endmodule

// File: tb/vcfg_unit_bench.sv
`timescale 1ns/1ps
module vcfg_unit_bench;
  localparam int XLEN = 32;
  localparam int VLEN = 128;
  localparam logic [31:0] VT_BAD = 32'h8000_0000;

  logic clk = 0, rst_n = 0, in_valid = 0, ext_f = 0, ext_d = 0;
  logic [31:0] instr = 0;
  logic [4:0] rs1_idx, rs2_idx, rd_idx;
  logic [31:0] rs1_val, rs2_val, rd_data, vl, vtype, vstart;
  logic rd_we, done, illegal;
  logic [31:0] gpr [32];
  int errors = 0, checks = 0;
  logic [31:0] exp_vl, exp_vt;

  always #2.5 clk = ~clk;
  assign rs1_val = gpr[rs1_idx];
  assign rs2_val = gpr[rs2_idx];

  vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN)) u_vcfg_unit (
    .clk, .rst_n, .in_valid, .instr, .ext_f, .ext_d, .rs1_idx, .rs1_val,
    .rs2_idx, .rs2_val, .rd_we, .rd_idx, .rd_data, .done, .illegal,
    .vl, .vtype, .vstart);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint unsigned m_vlmax(input logic [31:0] t);
    return (longint'(VLEN) << t[1:0]) >> (t[4:2] + 3);
  endfunction

  function automatic bit m_sew_ok(input logic [31:0] t, input bit f, input bit d);
    int xb = XLEN / 8;
    int mx = d ? (xb > 8 ? xb : 8) : (f ? (xb > 4 ? xb : 4) : xb);
    return (1 << t[4:2]) <= mx;
  endfunction

  function automatic logic [31:0] m_grant(input logic [4:0] r1, input logic [31:0] t);
    longint unsigned vm = m_vlmax(t), a = gpr[r1];
    if (r1 == 0) return 32'(vm);
    if (a <= vm) return 32'(a);
    if (a < 2 * vm) return 32'((a + 1) / 2);
    return 32'(vm);
  endfunction

  function automatic logic [31:0] enc_imm(input logic [10:0] z, input logic [4:0] r1, input logic [4:0] rd);
    return {1'b0, z, r1, 3'b111, rd, 7'b1010111};
  endfunction

  function automatic logic [31:0] enc_reg(input logic [4:0] r2, input logic [4:0] r1, input logic [4:0] rd);
    return {7'b1000000, r2, r1, 3'b111, rd, 7'b1010111};
  endfunction

  // kind: 0 = immediate form, 1 = register form, 2 = not a config word
  task automatic run(input logic [31:0] w, input int kind, input bit f, input bit d);
    logic [31:0] t;
    logic [4:0] r1 = w[19:15], r2 = w[24:20], rd = w[11:7];
    bit bad, sok, we;
    logic [31:0] g;
    @(negedge clk);
    instr = w; in_valid = 1; ext_f = f; ext_d = d;
    t = (kind == 0) ? 32'(w[30:20]) : gpr[r2];
    bad = (kind == 1) && r2 == 0;
    sok = m_sew_ok(t, f, d);
    g = m_grant(r1, t);
    we = 0;
    if (kind != 2) begin
      if (bad || !sok) exp_vt = VT_BAD;
      else begin exp_vt = t; exp_vl = g; we = (rd != 0); end
    end
    @(negedge clk);
    in_valid = 0;
    chk("R11 done", done, kind != 2);
    chk("R9 illegal", illegal, bad);
    chk("R10 rd_we", rd_we, we);
    if (we) begin
      chk("R8 rd_idx", rd_idx, rd);
      chk("R5 rd_data", rd_data, g);
    end
    chk("R7 vtype", vtype, exp_vt);
    chk("R8 vl", vl, exp_vl);
    chk("R8 vstart", vstart, 0);
    @(negedge clk);
    chk("R11 done pulse", done, 0);
    chk("R3 vl hold", vl, exp_vl);
  endtask

  bit finished = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] vt;
    longint unsigned vm;
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) gpr[i] = 0;
    exp_vl = 0; exp_vt = VT_BAD;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 vtype", vtype, VT_BAD);
    chk("R12 vl", vl, 0);
    chk("R12 vstart", vstart, 0);
    chk("R12 done", done, 0);
    chk("R12 rd_we", rd_we, 0);
    rst_n = 1;
    // R1/R4/R5 AVL band edges: SEW8 LMUL1 -> VLMAX 16
    gpr[3] = 5;  run(enc_imm(11'h000, 5'd3, 5'd7), 0, 0, 0);
    gpr[3] = 16; run(enc_imm(11'h000, 5'd3, 5'd7), 0, 0, 0);
    gpr[3] = 17; run(enc_imm(11'h000, 5'd3, 5'd7), 0, 0, 0);
    gpr[3] = 31; run(enc_imm(11'h000, 5'd3, 5'd7), 0, 0, 0);
    gpr[3] = 32; run(enc_imm(11'h000, 5'd3, 5'd7), 0, 0, 0);
    // R5 rs1 = x0, SEW16 LMUL8 -> 64
    run(enc_imm(11'h007, 5'd0, 5'd4), 0, 0, 0);
    // R10 rd = x0
    gpr[3] = 9; run(enc_imm(11'h001, 5'd3, 5'd0), 0, 0, 0);
    // R6/R7 SEW64 without D -> vill, then with D, SEW32 with F
    run(enc_imm(11'h00C, 5'd3, 5'd5), 0, 1, 0);
    run(enc_imm(11'h00C, 5'd3, 5'd5), 0, 0, 1);
    run(enc_imm(11'h008, 5'd3, 5'd5), 0, 1, 0);
    run(enc_imm(11'h010, 5'd3, 5'd5), 0, 1, 1);
    // R2 register form, R9 rs2 = x0
    gpr[6] = 32'h0000_0005; gpr[3] = 40;
    run(enc_reg(5'd6, 5'd3, 5'd8), 1, 0, 0);
    run(enc_reg(5'd0, 5'd3, 5'd8), 1, 0, 0);
    // R3 non-config words
    run(enc_imm(11'h000, 5'd3, 5'd7) ^ 32'h0000_1000, 2, 0, 0);
    run(enc_reg(5'd6, 5'd3, 5'd8) | 32'h4000_0000, 2, 0, 0);
    run(32'h0000_0013, 2, 0, 0);
    for (int n = 0; n < 400; n++) begin
      int kind = $urandom_range(0, 1);
      logic [4:0] r1 = 5'($urandom_range(0, 31));
      logic [4:0] r2 = 5'($urandom_range(0, 31));
      logic [4:0] rd = 5'($urandom_range(0, 31));
      vt = {25'd0, 7'($urandom)};
      if ($urandom_range(0, 3) != 0) vt[4] = 0;
      vm = m_vlmax(vt);
      if (vm == 0) vm = 1;
      case ($urandom_range(0, 4))
        0: gpr[1] = 32'($urandom_range(0, 32'(vm)));
        1: gpr[1] = 32'(vm + 1);
        2: gpr[1] = 32'(vm + $urandom_range(0, 32'(vm - 1)));
        3: gpr[1] = 32'(2 * vm - 1);
        default: gpr[1] = $urandom;
      endcase
      if (kind == 1) begin
        if (r2 == 1 || r2 == 0) r2 = ($urandom_range(0, 7) == 0) ? 5'd0 : 5'd2;
        gpr[r2] = vt;
        if (r1 != 0 && r1 != r2) gpr[r1] = gpr[1];
        gpr[0] = 0;
        run(enc_reg(r2, r1, rd), 1, 1'($urandom), 1'($urandom));
      end else begin
        if (r1 != 0) gpr[r1] = gpr[1];
        run(enc_imm(vt[10:0], r1, rd), 0, 1'($urandom), 1'($urandom));
      end
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule